// File: doc/BRIEF.md
# Five-Level Stacked-Carrier Sine PWM Generator

This block produces the level commands for a three-phase, five-level inverter leg set. One numerically controlled oscillator holds the phase of the first reference. The other two phases sit one third and two thirds of a turn further on. Each phase reads a quarter-wave sine table, is scaled by an amplitude word, and is compared against four triangular carriers. The carriers are stacked in fixed bands, two above zero and two below. The outcome is a signed level code from -2 to +2 for each phase, and downstream logic maps that code onto switch states.

All three phases share one up/down carrier counter, so each sees exactly the same carrier edges. The carrier half-period is a run-time setting given in clocks. The reference frequency is a phase increment per clock. An enable input freezes the whole generator when it is low.

Top module: `spwm5_gen`

## Requirements
- R1: While reset is asserted, all three level outputs read 0 (code 3'b000). An assertion of reset in mid-cycle forces them to 0 at once. After release, generation restarts from phase 0 and carrier count 0, counting upward.
- R2: While `en` is low, the phase, the carrier count and all three level outputs keep their values.
- R3: Each level output is a registered code in two's complement (-2=110, -1=111, 0=000, +1=001, +2=010). Let r be the reference and t the carrier in units of one band. The code equals [r>t] + [r>t+1] - [r<-t] - [r<-(t+1)], computed from the phase and carrier values held before the clock edge.
- R4: The carrier t is count/H, where H is the half-period setting. The count moves by one per enabled clock between 0 and H. It turns downward on reaching H and upward on reaching 0, which gives a period of 2H clocks.
- R5: The phase is an accumulator modulo 49152 that advances by `freq_inc` on each enabled clock. The reference in band units is (amp/4096)·sin(2π(s+0.5)/48), where s = phase/1024 is the sector index.
- R6: Phase B uses phase A plus 16384 modulo 49152, and phase C uses phase A plus 32768 modulo 49152.
- R7: Amplitude words above 8192 (two bands) act as exactly 8192.
- R8: A half-period setting of 0 acts as 1.
- R9: With `freq_inc` nonzero, 49152 must be divisible by 6·freq_inc·H, which makes the carrier-to-reference frequency ratio a whole multiple of 3. Under that rule, the level pattern of phase A repeats every 49152/freq_inc clocks, and phase B equals phase A taken 16384/freq_inc clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the whole generator |
| amp | input | 14 | Modulation amplitude, unsigned, 4096 = one band |
| freq_inc | input | 16 | Phase increment per clock, modulo 49152 |
| car_half | input | 12 | Carrier half-period in clocks |
| lvl_a | output | 3 | Phase A level code, signed |
| lvl_b | output | 3 | Phase B level code, signed |
| lvl_c | output | 3 | Phase C level code, signed |

## Verification
The carrier turn-around and a sector step of the sine reference can land on the same clock. Small half-periods such as 1 and 4, combined with large phase increments, make this happen many times per run. A cycle-by-cycle model, built from the requirements, then judges every phase on each of those clocks. A second coincidence is an enable drop, or a reset assertion, on a clock where the carrier would have reversed. This is judged by holding the outputs, and by checking after release that the carrier and phase continue exactly where the model expects.

// File: rtl/spwm5_pkg.sv
package spwm5_pkg;

  localparam int FRAC    = 12;            // fractional bits of one carrier band
  localparam int SECTORS = 48;            // sine sectors per turn
  localparam int QSECT   = SECTORS / 4;   // sectors per quarter wave
  localparam int MAG_W   = 15;            // sine magnitude width (Q15)

  typedef logic signed [2:0] lvl_t;

  // quarter-wave magnitude at sector midpoints, round(32767*sin((2a+1)*pi/48))
  function automatic logic [MAG_W-1:0] qsin(input logic [3:0] a);
    logic [MAG_W-1:0] m;
    case (a)
      4'd0:    m = 15'd2143;
      4'd1:    m = 15'd6393;
      4'd2:    m = 15'd10533;
      4'd3:    m = 15'd14492;
      4'd4:    m = 15'd18204;
      4'd5:    m = 15'd21605;
      4'd6:    m = 15'd24636;
      4'd7:    m = 15'd27245;
      4'd8:    m = 15'd29388;
      4'd9:    m = 15'd31028;
      4'd10:   m = 15'd32137;
      default: m = 15'd32697;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/spwm5_phase_acc.sv
module spwm5_phase_acc #(
  parameter int PW  = 16,
  parameter int MOD = 49152
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] inc,
  output logic [PW-1:0] ph_a,
  output logic [PW-1:0] ph_b,
  output logic [PW-1:0] ph_c
);
  localparam int THIRD = MOD / 3;

  if (MOD % 3 != 0) begin : g_bad_mod
    $error("phase modulus must divide by three");
  end

  logic [PW-1:0] ph_q, ph_nx;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] a, input logic [PW:0] b);
    logic [PW:0] s;
    s = (PW+1)'(a) + b;
    if (s >= (PW+1)'(MOD)) s = s - (PW+1)'(MOD);
    return s[PW-1:0];
  endfunction

  always_comb begin
    ph_nx = ph_q;
    if (en) ph_nx = wrap_add(ph_q, (PW+1)'(inc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_nx;
  end

  assign ph_a = ph_q;
  assign ph_b = wrap_add(ph_q, (PW+1)'(THIRD));
  assign ph_c = wrap_add(ph_q, (PW+1)'(2 * THIRD));

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < PW'(MOD)); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ph_q)); // R2
endmodule

// File: rtl/spwm5_carrier.sv
module spwm5_carrier #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] half,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] heff
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          up_q, up_nx;

  assign heff = (half == '0) ? CW'(1) : half;

  always_comb begin
    cnt_nx = cnt_q;
    up_nx  = up_q;
    if (en) begin
      if (up_q) begin
        if ((CW+1)'(cnt_q) + 1'b1 >= (CW+1)'(heff)) begin
          cnt_nx = heff;
          up_nx  = 1'b0;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q <= CW'(1)) begin
          cnt_nx = '0;
          up_nx  = 1'b1;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      up_q  <= up_nx;
    end
  end

  assign cnt = cnt_q;

  AST_CARRIER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R2
  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q > '0 && cnt_q < heff) |=>
      (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/spwm5_sine_ref.sv
module spwm5_sine_ref
  import spwm5_pkg::*;
#(
  parameter int PW = 16,
  parameter int AW = 14,
  parameter int RW = 16
) (
  input  logic [PW-1:0]        ph,
  input  logic [AW-1:0]        amp,
  output logic signed [RW-1:0] ref_o
);
  localparam int SW    = 6;
  localparam int FULL  = 1 << (FRAC + 1);
  localparam int PRODW = AW + MAG_W;

  logic [SW-1:0]    sec, idx;
  logic             neg;
  logic [AW-1:0]    ampc;
  logic [MAG_W-1:0] mag;
  logic [PRODW-1:0] prod;
  logic [AW-1:0]    scaled;

  assign sec = ph[PW-1 -: SW];

  always_comb begin
    if (sec < SW'(QSECT)) begin
      idx = sec;                     neg = 1'b0;
    end else if (sec < SW'(2 * QSECT)) begin
      idx = SW'(2 * QSECT - 1) - sec; neg = 1'b0;
    end else if (sec < SW'(3 * QSECT)) begin
      idx = sec - SW'(2 * QSECT);     neg = 1'b1;
    end else begin
      idx = SW'(4 * QSECT - 1) - sec; neg = 1'b1;
    end
  end

  always_comb begin
    ampc = (amp > AW'(FULL)) ? AW'(FULL) : amp;
    mag  = qsin(idx[3:0]);
    prod = PRODW'(ampc) * PRODW'(mag);
    scaled = prod[PRODW-1 -: AW];
    ref_o  = neg ? -$signed(RW'(scaled)) : $signed(RW'(scaled));
  end
endmodule

// File: rtl/spwm5_level_cmp.sv
module spwm5_level_cmp
  import spwm5_pkg::*;
#(
  parameter int RW  = 16,
  parameter int CW  = 12,
  parameter int PRW = 32
) (
  input  logic signed [RW-1:0] ref_i,
  input  logic [CW-1:0]        cnt,
  input  logic [CW-1:0]        heff,
  output lvl_t                 lvl
);
  logic signed [PRW-1:0] lhs, c_lo, c_hi;
  int sum;

  always_comb begin
    lhs  = $signed(PRW'(ref_i)) * $signed(PRW'(heff));
    c_lo = $signed(PRW'(cnt) << FRAC);
    c_hi = $signed((PRW'(cnt) + PRW'(heff)) << FRAC);
    sum  = int'(lhs > c_lo) + int'(lhs > c_hi) - int'(lhs < -c_lo) - int'(lhs < -c_hi);
    lvl  = lvl_t'(sum);
  end
endmodule

// File: rtl/spwm5_gen.sv
module spwm5_gen
  import spwm5_pkg::*;
#(
  parameter int PW  = 16,
  parameter int AW  = 14,
  parameter int CW  = 12,
  parameter int MOD = 49152
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] amp,
  input  logic [PW-1:0] freq_inc,
  input  logic [CW-1:0] car_half,
  output logic [2:0]    lvl_a,
  output logic [2:0]    lvl_b,
  output logic [2:0]    lvl_c
);
  localparam int RW     = AW + 2;
  localparam int NPHASE = 3;

  logic rs1, rs2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end

  logic [PW-1:0] ph [NPHASE];
  logic [CW-1:0] cnt, heff;

  spwm5_phase_acc #(.PW(PW), .MOD(MOD)) u_phase (
    .clk(clk), .rst_n(rs2), .en(en), .inc(freq_inc),
    .ph_a(ph[0]), .ph_b(ph[1]), .ph_c(ph[2])
  );

  spwm5_carrier #(.CW(CW)) u_carrier (
    .clk(clk), .rst_n(rs2), .en(en), .half(car_half),
    .cnt(cnt), .heff(heff)
  );

  lvl_t lvl_d [NPHASE];
  lvl_t lvl_nx [NPHASE];
  lvl_t lvl_q [NPHASE];

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    logic signed [RW-1:0] ref_v;
    spwm5_sine_ref #(.PW(PW), .AW(AW), .RW(RW)) u_ref (
      .ph(ph[p]), .amp(amp), .ref_o(ref_v)
    );
    spwm5_level_cmp #(.RW(RW), .CW(CW)) u_cmp (
      .ref_i(ref_v), .cnt(cnt), .heff(heff), .lvl(lvl_d[p])
    );
    always_comb lvl_nx[p] = en ? lvl_d[p] : lvl_q[p];
    always_ff @(posedge clk or negedge rs2) begin
      if (!rs2) lvl_q[p] <= '0;
      else      lvl_q[p] <= lvl_nx[p];
    end
  end

  assign lvl_a = lvl_q[0];
  assign lvl_b = lvl_q[1];
  assign lvl_c = lvl_q[2];

  AST_RESET_LEVELS: assert property (@(posedge clk)
    !rs2 |-> (lvl_a == '0 && lvl_b == '0 && lvl_c == '0)); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rs2)
    ($signed(lvl_a) >= -3'sd2 && $signed(lvl_b) >= -3'sd2 && $signed(lvl_c) >= -3'sd2)); // R3
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rs2)
    !en |=> ($stable(lvl_a) && $stable(lvl_b) && $stable(lvl_c))); // R2
  AST_ZERO_AMP: assert property (@(posedge clk) disable iff (!rs2)
    (en && amp == '0) |=> (lvl_a == '0 && lvl_b == '0 && lvl_c == '0)); // R3
  AST_RATIO_MULT3: assert property (@(posedge clk) disable iff (!rs2)
    (en && freq_inc != '0) |-> ((MOD % (6 * int'(freq_inc) * int'(heff))) == 0)); // R9
endmodule

// File: tb/spwm5_gen_test.sv
module spwm5_gen_test;
  localparam int MODV = 49152;
  localparam int NV   = 6;
  localparam int V_AMP  [NV] = '{8192, 4096, 10000, 0,  6000, 8192};
  localparam int V_INC  [NV] = '{64,   128,  256,   32, 16,   512};
  localparam int V_HALF [NV] = '{8,    16,   4,     32, 64,   0};
  localparam int V_LEN  [NV] = '{800,  500,  400,   200, 700, 300};

  logic clk = 1'b0;
  logic rst_n, en;
  logic [13:0] amp;
  logic [15:0] freq_inc;
  logic [11:0] car_half;
  logic signed [2:0] lvl_a, lvl_b, lvl_c;

  always #10 clk = ~clk;

  spwm5_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .amp(amp), .freq_inc(freq_inc),
    .car_half(car_half), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  int m_ph, m_cnt;
  bit m_up;
  int m_lvl [3];
  bit rec;
  int rec_n;
  int rec_a [1024];
  int rec_b [1024];

  function automatic string vtag(int v);
    case (v)
      0: return "R3";
      1: return "R4";
      2: return "R7";
      3: return "R3";
      4: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic int model_lvl(int ph, int av, int cv, int hv, output bit amb);
    real ang, r, t1, t2;
    int s, a;
    s = ph / 1024;
    ang = (real'(s) + 0.5) * 2.0 * 3.14159265358979 / 48.0;
    a = (av > 8192) ? 8192 : av;
    r = real'(a) * $sin(ang);
    t1 = real'(cv) * 4096.0 / real'(hv);
    t2 = t1 + 4096.0;
    amb = ((r - t1) < 4.0 && (t1 - r) < 4.0) || ((r - t2) < 4.0 && (t2 - r) < 4.0) ||
          ((r + t1) < 4.0 && (-t1 - r) < 4.0) || ((r + t2) < 4.0 && (-t2 - r) < 4.0);
    return int'(r > t1) + int'(r > t2) - int'(r < -t1) - int'(r < -t2);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_cnt = 0; m_up = 1'b1;
    for (int p = 0; p < 3; p++) m_lvl[p] = 0;
  endtask

  // called just after a negedge with inputs set; returns at the next negedge
  task automatic run_cycle(string req);
    int exp [3];
    bit amb [3];
    int act [3];
    int hv;
    hv = (car_half == 0) ? 1 : int'(car_half);
    for (int p = 0; p < 3; p++) begin
      if (en) exp[p] = model_lvl((m_ph + p * 16384) % MODV, int'(amp), m_cnt, hv, amb[p]);
      else begin
        exp[p] = m_lvl[p];
        amb[p] = 1'b0;
      end
    end
    if (en) begin
      m_ph = (m_ph + int'(freq_inc)) % MODV;
      if (m_up) begin
        if (m_cnt + 1 >= hv) begin m_cnt = hv; m_up = 1'b0; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt <= 1) begin m_cnt = 0; m_up = 1'b1; end
        else m_cnt = m_cnt - 1;
      end
    end
    @(posedge clk);
    #5;
    act[0] = int'(lvl_a); act[1] = int'(lvl_b); act[2] = int'(lvl_c);
    for (int p = 0; p < 3; p++) begin
      if (!amb[p]) check(req, $sformatf("phase %0d level", p), act[p], exp[p]);
      m_lvl[p] = act[p];
    end
    if (rec && rec_n < 1024) begin
      rec_a[rec_n] = act[0];
      rec_b[rec_n] = act[1];
      rec_n++;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; en = 1'b0; amp = '0; freq_inc = '0; car_half = 12'd1;
    rec = 1'b0; rec_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: levels forced to zero in reset
    check("R1", "reset lvl_a", int'(lvl_a), 0);
    check("R1", "reset lvl_b", int'(lvl_b), 0);
    check("R1", "reset lvl_c", int'(lvl_c), 0);
    rst_n = 1'b1;
    amp = 14'd8192;
    for (int k = 0; k < 4; k++) run_cycle("R1");

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      amp = 14'(V_AMP[v]); freq_inc = 16'(V_INC[v]); car_half = 12'(V_HALF[v]);
      en = 1'b1;
      for (int k = 0; k < V_LEN[v]; k++) run_cycle(vtag(v));
    end

    // R2: enable low freezes everything, then resumes in step with the model
    amp = 14'd7000; freq_inc = 16'd128; car_half = 12'd4;
    for (int k = 0; k < 9; k++) run_cycle("R2");
    en = 1'b0;
    for (int k = 0; k < 20; k++) run_cycle("R2");
    en = 1'b1;
    for (int k = 0; k < 60; k++) run_cycle("R2");

    // R9 / R6: period of phase A, and B leading A by a third of a turn
    amp = 14'd7000; freq_inc = 16'd64; car_half = 12'd8;
    for (int k = 0; k < 40; k++) run_cycle("R6");
    rec = 1'b1; rec_n = 0;
    for (int k = 0; k < 1024; k++) run_cycle("R6");
    rec = 1'b0;
    for (int t = 0; t < 256; t++) check("R9", "phase A repeats after 768 clocks", rec_a[t + 768], rec_a[t]);
    for (int t = 0; t < 768; t++) check("R6", "phase B equals A 256 clocks later", rec_b[t], rec_a[t + 256]);

    // R1: asynchronous reset in mid-cycle, then restart from phase 0
    amp = 14'd8192; freq_inc = 16'd256; car_half = 12'd4;
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1;
    check("R1", "async reset lvl_a", int'(lvl_a), 0);
    check("R1", "async reset lvl_b", int'(lvl_b), 0);
    check("R1", "async reset lvl_c", int'(lvl_c), 0);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    en = 1'b1;
    for (int k = 0; k < 200; k++) run_cycle("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule